// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte-address sequence for one DMA channel whose transfer follows a nested two-level geometry. Software programs a small set of registers: a base address, a beat-size code, three geometry words that hold row widths, row counts, a tile repeat count and a slice count, and five signed skip offsets. A start pulse then launches the walk. The generator emits one request per beat, as an address and a byte count, on a valid/ready handshake. It raises a one-cycle done pulse at the end. It also reports the bytes moved and the total address span covered.

The walk runs through slices. Each full slice holds `xn` "a" tiles and then one "b" tile. An "a" tile is `ya+1` rows of `xa` bytes. The "b" tile is `ya+1` rows of `xb` bytes. There are `yn` full slices. After them comes one closing slice with the same tile layout, but its tiles have `yb+1` rows. Between rows of a tile, a row skip is added to the address. At the end of each tile, a tile skip is added. Which skip applies depends on the tile kind and on whether the slice is the closing one.

The block is used by a channel controller. The controller programs the registers, pulses start, and turns each accepted request into a bus burst. The controller is outside this block.

Top module: `dma2d_agen`

## Requirements
- R1: Register map, all registers 32 bits wide. The map has these registers:
  - 0x00 status: bit 0 is busy. It is read-only.
  - 0x04 control: bits [1:0] are the beat code. The whole word reads back as written.
  - 0x0C holds xn in [15:0] and yn in [31:16].
  - 0x10 holds xb in [15:0] and yb in [31:16].
  - 0x14 holds xa in [15:0] and ya in [31:16].
  - 0x18 is the b row skip, 0x1C the closing-slice a tile skip, 0x20 the a row skip, 0x24 the full-slice a tile skip, and 0x28 the b tile skip.
  - Geometry and skip registers read back exactly as written.
- R2: The two row skips are signed values of width OFF1_W (default 17). The three tile skips are signed values of width OFF2_W (default 28). Bits above each width are ignored, and the value is sign-extended to 32 bits.
- R3: Order of a full slice. A full slice emits xn "a" tiles, each of ya+1 rows of xa bytes. Then it emits one "b" tile of ya+1 rows of xb bytes. Skips are applied as follows:
  - An a row skip is applied after each a row except the tile's last.
  - The full-slice a tile skip is applied after each a tile.
  - A b row skip is applied between b rows.
  - The b tile skip is applied after the b tile.
  - The tile skip for xn=0 is the "b" tile only.
- R4: After yn full slices, one closing slice runs. It is laid out the same way, but with yb+1 rows per tile, and the closing-slice a tile skip replaces the full-slice one.
- R5: Beat code 0, 1, 2 or 3 selects 2, 4, 8 or 16 bytes per beat. Each row is issued as consecutive beats, starting at the row's first address and stepping by the beat size. Row widths are multiples of the beat size.
- R6: A row of width zero issues no beat. Its skip is still added to the address.
- R7: While req_valid is high and req_ready is low, req_valid, req_addr and req_bytes hold their values.
- R8: done is a one-cycle pulse in the cycle after the final row's step. When the walk ends on a non-empty row, that is the cycle after the last accepted beat. Busy is cleared in the same cycle. At that point bytes_moved equals (xa·(ya+1)·xn + xb·(ya+1))·yn + xa·(yb+1)·xn + xb·(yb+1).
- R9: At done, span_bytes (the final address minus the base, modulo 2^32) equals the span formula. The formula is (((xa+ra)·ya + xa + ta_full)·xn + (xb+rb)·ya + xb + tb)·yn + ((xa+ra)·yb + xa + ta_close)·xn + (xb+rb)·yb + xb + tb. Here ra and rb are the a and b row skips, ta_full and ta_close are the full-slice and closing-slice a tile skips, and tb is the b tile skip.
- R10: A start pulse while busy is ignored. Configuration is sampled only when a walk starts, so register writes during a walk do not change the request stream.
- R11: While busy, a read of 0x08 returns the current request address. While idle, it returns the programmed base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| start | input | 1 | Launches a walk when idle |
| req_valid | output | 1 | A beat request is presented |
| req_ready | input | 1 | Consumer accepts the presented beat |
| req_addr | output | 32 | Byte address of the beat |
| req_bytes | output | 5 | Bytes in the beat (2, 4, 8 or 16) |
| done | output | 1 | One-cycle end-of-walk pulse |
| bytes_moved | output | 32 | Bytes accepted since the last start |
| span_bytes | output | 32 | Current address minus base of the last walk |

## Verification
The bench goes after these corner cases of the walk:
- Skip registers with junk above the signed width and with the sign bit set. A design that did not mask or sign-extend would put every later address off by a large constant.
- A job with yn=0 and a job with xn=0. A design that swapped the row counts of full and closing slices, or that always ran at least one "a" tile, would emit extra beats or use the wrong tile skip.
- A zero-width "b" tile at the very end. A design that skipped the offset of an empty row would miss the skips in the next slice's addresses. It would also finish too early, since done must trail the last beat by the empty rows' steps.
- A stalled consumer, a restart pulse, and a geometry rewrite, all in mid-walk. A design that reloaded would restart the stream, and a design that dropped a held beat would fail the scoreboard.

// File: rtl/dma2d_pkg.sv
// dma2d_pkg: shared types and register offsets of the 2-D DMA address
// generator. Assumes a 32-bit address space and 16-bit geometry fields.
package dma2d_pkg;
    localparam int ADDR_W = 32;
    localparam int FLD_W  = 16;
    localparam int BYTES_W = 5;
    localparam int NUM_SKIP = 5;

    // Beat size code held in control bits [1:0]
    typedef enum logic [1:0] {
        BEAT_2  = 2'd0,
        BEAT_4  = 2'd1,
        BEAT_8  = 2'd2,
        BEAT_16 = 2'd3
    } beat_e;

    // Walk geometry, as latched at start
    typedef struct packed {
        logic [FLD_W-1:0] xa;
        logic [FLD_W-1:0] xb;
        logic [FLD_W-1:0] xn;
        logic [FLD_W-1:0] ya;
        logic [FLD_W-1:0] yb;
        logic [FLD_W-1:0] yn;
    } geom_t;

    // Sign-extended skips
    typedef struct packed {
        logic [ADDR_W-1:0] row_a;
        logic [ADDR_W-1:0] row_b;
        logic [ADDR_W-1:0] tile_a_full;
        logic [ADDR_W-1:0] tile_a_close;
        logic [ADDR_W-1:0] tile_b;
    } skips_t;

    // Skip array index order used between regs, extenders and walker
    localparam int SK_ROW_A   = 0;
    localparam int SK_ROW_B   = 1;
    localparam int SK_TA_FULL = 2;
    localparam int SK_TA_CLOSE = 3;
    localparam int SK_TB      = 4;

    localparam logic [5:0] RA_STATUS  = 6'h00;
    localparam logic [5:0] RA_CTRL    = 6'h04;
    localparam logic [5:0] RA_PTR     = 6'h08;
    localparam logic [5:0] RA_COUNTS  = 6'h0C;
    localparam logic [5:0] RA_BSIZE   = 6'h10;
    localparam logic [5:0] RA_ASIZE   = 6'h14;
    localparam logic [5:0] RA_RSKIP_B = 6'h18;
    localparam logic [5:0] RA_TSKIP_AC = 6'h1C;
    localparam logic [5:0] RA_RSKIP_A = 6'h20;
    localparam logic [5:0] RA_TSKIP_AF = 6'h24;
    localparam logic [5:0] RA_TSKIP_B = 6'h28;
endpackage

// File: rtl/dma2d_sext.sv
// dma2d_sext: sign-extends the low W bits of a 32-bit word to 32 bits,
// ignoring the bits above W. Assumes 1 <= W <= 32.
module dma2d_sext #(
    parameter int W = 17
) (
    input  logic [31:0] raw,
    output logic [31:0] ext
);
    localparam int SH = 32 - W;

    logic [31:0] lifted;

    // Move the sign bit to bit 31, then shift back arithmetically
    always_comb begin
        lifted = raw << SH;
        ext    = $unsigned($signed(lifted) >>> SH);
    end
endmodule

// File: rtl/dma2d_regs.sv
// dma2d_regs: register file and read decode of the generator. Holds the
// base, control, geometry and raw skip words; status and pointer reads
// reflect the walker. Assumes word-aligned offsets on cfg_addr.
module dma2d_regs
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_addr,
    output geom_t             geom,
    output logic [ADDR_W-1:0] base,
    output beat_e             beat_code,
    output logic [31:0]       skip_raw [NUM_SKIP]
);
    logic [31:0] ctrl_q;
    logic [31:0] counts_q, bsize_q, asize_q;

    // Register writes; status is read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base     <= '0;
            ctrl_q   <= '0;
            counts_q <= '0;
            bsize_q  <= '0;
            asize_q  <= '0;
            for (int i = 0; i < NUM_SKIP; i++) skip_raw[i] <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                RA_CTRL:     ctrl_q   <= cfg_wdata;
                RA_PTR:      base     <= cfg_wdata;
                RA_COUNTS:   counts_q <= cfg_wdata;
                RA_BSIZE:    bsize_q  <= cfg_wdata;
                RA_ASIZE:    asize_q  <= cfg_wdata;
                RA_RSKIP_A:  skip_raw[SK_ROW_A]    <= cfg_wdata;
                RA_RSKIP_B:  skip_raw[SK_ROW_B]    <= cfg_wdata;
                RA_TSKIP_AF: skip_raw[SK_TA_FULL]  <= cfg_wdata;
                RA_TSKIP_AC: skip_raw[SK_TA_CLOSE] <= cfg_wdata;
                RA_TSKIP_B:  skip_raw[SK_TB]       <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // Unpack geometry halves
    always_comb begin
        geom.xn   = counts_q[15:0];
        geom.yn   = counts_q[31:16];
        geom.xb   = bsize_q[15:0];
        geom.yb   = bsize_q[31:16];
        geom.xa   = asize_q[15:0];
        geom.ya   = asize_q[31:16];
        beat_code = beat_e'(ctrl_q[1:0]);
    end

    // Read decode
    always_comb begin
        case (cfg_addr)
            RA_STATUS:   cfg_rdata = {31'd0, busy};
            RA_CTRL:     cfg_rdata = ctrl_q;
            RA_PTR:      cfg_rdata = busy ? cur_addr : base;
            RA_COUNTS:   cfg_rdata = counts_q;
            RA_BSIZE:    cfg_rdata = bsize_q;
            RA_ASIZE:    cfg_rdata = asize_q;
            RA_RSKIP_A:  cfg_rdata = skip_raw[SK_ROW_A];
            RA_RSKIP_B:  cfg_rdata = skip_raw[SK_ROW_B];
            RA_TSKIP_AF: cfg_rdata = skip_raw[SK_TA_FULL];
            RA_TSKIP_AC: cfg_rdata = skip_raw[SK_TA_CLOSE];
            RA_TSKIP_B:  cfg_rdata = skip_raw[SK_TB];
            default:     cfg_rdata = '0;
        endcase
    end

    // R11
    ptr_idle_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_addr == RA_PTR) |-> cfg_rdata == base);
endmodule

// File: rtl/dma2d_walker.sv
// dma2d_walker: the nested slice/tile/row/beat sequencer. Latches the
// configuration on an accepted start, issues one request per beat, and
// applies a skip at every row end. A zero-width row takes one cycle.
// Assumes row widths are multiples of the beat size.
module dma2d_walker
    import dma2d_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  geom_t              geom_in,
    input  skips_t             skips_in,
    input  logic [ADDR_W-1:0]  base_in,
    input  beat_e              beat_code,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [BYTES_W-1:0] req_bytes,
    output logic               busy,
    output logic               done,
    output logic               launch,
    output logic               fire
);
    geom_t              g;
    skips_t             sk;
    logic [BYTES_W-1:0] bsz;
    logic [ADDR_W-1:0]  addr;
    logic [FLD_W-1:0]   row, tile, slice, col;

    logic               close_slc, b_tile, last_row, row_end, walk_end;
    logic [FLD_W-1:0]   width, row_lim;
    logic [FLD_W:0]     col_next;
    logic [ADDR_W-1:0]  skip, addr_adv;

    // Position decode and row-end step
    always_comb begin
        close_slc = (slice == g.yn);
        b_tile    = (tile == g.xn);
        row_lim   = close_slc ? g.yb : g.ya;
        last_row  = (row == row_lim);
        width     = b_tile ? g.xb : g.xa;
        col_next  = {1'b0, col} + {{(FLD_W+1-BYTES_W){1'b0}}, bsz};
        req_valid = busy && (col < width);
        fire      = req_valid && req_ready;
        launch    = start && !busy;
        row_end   = busy && (req_valid ? (req_ready && col_next >= {1'b0, width}) : 1'b1);
        walk_end  = row_end && last_row && b_tile && close_slc;
        if (!last_row)
            skip = b_tile ? sk.row_b : sk.row_a;
        else if (b_tile)
            skip = sk.tile_b;
        else
            skip = close_slc ? sk.tile_a_close : sk.tile_a_full;
        addr_adv  = addr + (fire ? {{(ADDR_W-BYTES_W){1'b0}}, bsz} : '0);
        req_addr  = addr;
        req_bytes = bsz;
    end

    // Sequencer state: latch on launch, step beats and rows while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            g     <= '0;
            sk    <= '0;
            bsz   <= 5'd2;
            addr  <= '0;
            row   <= '0;
            tile  <= '0;
            slice <= '0;
            col   <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                busy  <= 1'b1;
                g     <= geom_in;
                sk    <= skips_in;
                bsz   <= 5'd2 << beat_code;
                addr  <= base_in;
                row   <= '0;
                tile  <= '0;
                slice <= '0;
                col   <= '0;
            end else if (row_end) begin
                addr <= addr_adv + skip;
                col  <= '0;
                if (!last_row) begin
                    row <= row + 1'b1;
                end else begin
                    row <= '0;
                    if (!b_tile) begin
                        tile <= tile + 1'b1;
                    end else begin
                        tile <= '0;
                        if (!close_slc) slice <= slice + 1'b1;
                    end
                end
                if (walk_end) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (fire) begin
                addr <= addr_adv;
                col  <= col_next[FLD_W-1:0];
            end
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_bytes)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R5
    beat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_bytes) == 1 && !req_bytes[0]));
    // R10
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(g) && $stable(sk)));
endmodule

// File: rtl/dma2d_tally.sv
// dma2d_tally: counts accepted bytes since the last launch and reports
// the address span walked from the latched base. Assumes fire and
// launch never coincide.
module dma2d_tally
    import dma2d_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               fire,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [ADDR_W-1:0]  base_in,
    input  logic [ADDR_W-1:0]  cur_addr,
    output logic [31:0]        bytes_moved,
    output logic [ADDR_W-1:0]  span_bytes
);
    logic [ADDR_W-1:0] base_q;

    // Byte counter and base latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_moved <= '0;
            base_q      <= '0;
        end else if (launch) begin
            bytes_moved <= '0;
            base_q      <= base_in;
        end else if (fire) begin
            bytes_moved <= bytes_moved + {{(32-BYTES_W){1'b0}}, req_bytes};
        end
    end

    // Span from base to present pointer
    always_comb span_bytes = cur_addr - base_q;

    // R8
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> bytes_moved == $past(bytes_moved) + {27'd0, $past(req_bytes)});
endmodule

// File: rtl/dma2d_agen.sv
// dma2d_agen: top of the 2-D DMA address generator. Wires the register
// file, the skip sign extenders (one per skip, width chosen by kind),
// the walker and the tally. Assumes OFF1_W and OFF2_W in 1..32.
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int OFF1_W = 17,
    parameter int OFF2_W = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        start,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [31:0] req_addr,
    output logic [4:0]  req_bytes,
    output logic        done,
    output logic [31:0] bytes_moved,
    output logic [31:0] span_bytes
);
    geom_t       geom;
    skips_t      skips;
    beat_e       beat_code;
    logic [31:0] base;
    logic [31:0] skip_raw [NUM_SKIP];
    logic [31:0] skip_ext [NUM_SKIP];
    logic        busy, launch, fire;

    dma2d_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .cur_addr  (req_addr),
        .geom      (geom),
        .base      (base),
        .beat_code (beat_code),
        .skip_raw  (skip_raw)
    );

    for (genvar gi = 0; gi < NUM_SKIP; gi++) begin : g_sext
        localparam int WSEL = (gi == SK_ROW_A || gi == SK_ROW_B) ? OFF1_W : OFF2_W;
        dma2d_sext #(.W(WSEL)) u_sext (
            .raw (skip_raw[gi]),
            .ext (skip_ext[gi])
        );
    end

    // Pack extended skips for the walker
    always_comb begin
        skips.row_a        = skip_ext[SK_ROW_A];
        skips.row_b        = skip_ext[SK_ROW_B];
        skips.tile_a_full  = skip_ext[SK_TA_FULL];
        skips.tile_a_close = skip_ext[SK_TA_CLOSE];
        skips.tile_b       = skip_ext[SK_TB];
    end

    dma2d_walker u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .geom_in   (geom),
        .skips_in  (skips),
        .base_in   (base),
        .beat_code (beat_code),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .busy      (busy),
        .done      (done),
        .launch    (launch),
        .fire      (fire)
    );

    dma2d_tally u_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .fire        (fire),
        .req_bytes   (req_bytes),
        .base_in     (base),
        .cur_addr    (req_addr),
        .bytes_moved (bytes_moved),
        .span_bytes  (span_bytes)
    );
endmodule

// File: tb/dma2d_agen_bench.sv
module dma2d_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = 6'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic [4:0]  req_bytes;
    logic        done;
    logic [31:0] bytes_moved;
    logic [31:0] span_bytes;

    int tests = 0;
    int fails = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;
    logic [36:0] exp_q[$];

    dma2d_agen u_dma2d_agen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .done(done), .bytes_moved(bytes_moved),
        .span_bytes(span_bytes)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input int w);
        logic [31:0] m;
        if (w >= 32) return v;
        m = v & ((32'h1 << w) - 1);
        if (v[w-1]) m = m | ~((32'h1 << w) - 1);
        return m;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 check(req, cfg_rdata, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Ready driver: always ready, or stalls one cycle in three
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    // Monitor: pop expected beats as they are accepted (R3 R4 R5 R7)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid && req_ready) begin
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R3: unexpected beat addr %h expected none", req_addr);
                end else begin
                    logic [36:0] e;
                    e = exp_q.pop_front();
                    check("R3/R4 beat address", req_addr, e[36:5]);
                    check("R5 beat bytes", {27'd0, req_bytes}, {27'd0, e[4:0]});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Program, build expected stream and totals, run, and check the end
    task automatic run_job(input logic [31:0] base, input int code,
                           input int xa, input int xb, input int xn,
                           input int ya, input int yb, input int yn,
                           input logic [31:0] ra_raw, input logic [31:0] rb_raw,
                           input logic [31:0] taf_raw, input logic [31:0] tac_raw,
                           input logic [31:0] tb_raw, input bit mid_poke);
        logic [31:0] ra, rb, taf, tac, tb, a, tot, span;
        int bs, n;
        ra = sx(ra_raw, 17); rb = sx(rb_raw, 17);
        taf = sx(taf_raw, 28); tac = sx(tac_raw, 28); tb = sx(tb_raw, 28);
        bs = 2 << code;
        wr(6'h08, base);
        wr(6'h04, code);
        wr(6'h0C, {yn[15:0], xn[15:0]});
        wr(6'h10, {yb[15:0], xb[15:0]});
        wr(6'h14, {ya[15:0], xa[15:0]});
        wr(6'h20, ra_raw); wr(6'h18, rb_raw);
        wr(6'h24, taf_raw); wr(6'h1C, tac_raw); wr(6'h28, tb_raw);
        a = base;
        for (int s = 0; s <= yn; s++) begin
            for (int t = 0; t <= xn; t++) begin
                int rl, w;
                bit bt, fin;
                fin = (s == yn); bt = (t == xn);
                rl = fin ? yb : ya; w = bt ? xb : xa;
                for (int r = 0; r <= rl; r++) begin
                    for (int c = 0; c < w; c += bs) exp_q.push_back({a + c, bs[4:0]});
                    a = a + w + ((r < rl) ? (bt ? rb : ra) : (bt ? tb : (fin ? tac : taf)));
                end
            end
        end
        tot = (xa*(ya+1)*xn + xb*(ya+1))*yn + xa*(yb+1)*xn + xb*(yb+1);
        span = (((xa+ra)*ya + xa + taf)*xn + (xb+rb)*ya + xb + tb)*yn
             + ((xa+ra)*yb + xa + tac)*xn + (xb+rb)*yb + xb + tb;
        pulse_start();
        if (mid_poke) begin
            repeat (3) @(negedge clk);
            cfg_addr = 6'h08;
            #1 check("R11 pointer read while busy", cfg_rdata, req_addr);
            cfg_addr = 6'h00;
            #1 check("R10 busy during walk", cfg_rdata, 32'd1);
            wr(6'h14, 32'h0003_0010);
            pulse_start();
        end
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk); #2; n++;
        end
        check("R3 all beats issued", exp_q.size(), 0);
        cfg_addr = 6'h00;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!done && n < 50);
        check("R8/R6 done delay", n, (xb != 0) ? 1 : yb + 2);
        #1;
        check("R8 busy clear at done", cfg_rdata, 32'd0);
        check("R8 bytes moved", bytes_moved, tot);
        check("R9 span", span_bytes, span);
        @(negedge clk);
        check("R8 done one cycle", {31'd0, done}, 32'd0);
        if (mid_poke) check("R10 no relaunch", {31'd0, req_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", cfg_rdata, 32'd0);
        check("R8 reset done", {31'd0, done}, 32'd0);
        check("R7 reset valid", {31'd0, req_valid}, 32'd0);
        check("R8 reset bytes", bytes_moved, 32'd0);

        // R1 register readback and read-only status
        wr(6'h0C, 32'h1234_5678);
        rd_check("R1 counts word", 6'h0C, 32'h1234_5678);
        wr(6'h28, 32'hDEAD_BEEF);
        rd_check("R1 tile skip raw", 6'h28, 32'hDEAD_BEEF);
        wr(6'h04, 32'hA5A5_0002);
        rd_check("R1 control word", 6'h04, 32'hA5A5_0002);
        wr(6'h00, 32'hFFFF_FFFF);
        rd_check("R1 status read-only", 6'h00, 32'd0);
        wr(6'h08, 32'h0000_4000);
        rd_check("R11 pointer idle is base", 6'h08, 32'h0000_4000);

        // R2 R3 R4 R5: beat 4, junk above signed widths, negative skips
        run_job(32'h0000_1000, 1, 8, 4, 2, 1, 0, 2,
                32'hABC1_FFFC, 32'h0000_0010, 32'hF000_0020, 32'h0FFF_FFF0,
                32'h0000_0100, 1'b0);
        // R6: zero-width b tile at the end, beat 16
        run_job(32'h0001_0000, 3, 32, 0, 1, 2, 1, 1,
                32'h0000_0040, 32'h0000_1000, 32'h0000_0100, 32'h0000_0200,
                32'h0000_2000, 1'b0);
        // R4 R5: xn=0, beat 8, negative b skips
        run_job(32'h0002_0000, 2, 8, 16, 0, 0, 2, 3,
                32'h0000_0008, 32'h0001_FFF0, 32'h0000_0000, 32'h0000_0000,
                32'h0FFF_FF00, 1'b0);
        // R7 R10 R11: yn=0, beat 2, stalls, mid-walk rewrite and restart
        stall_mode = 1'b1;
        run_job(32'h0003_0000, 0, 4, 2, 3, 0, 1, 0,
                32'h0000_0002, 32'h0000_0006, 32'h0000_0000, 32'h0000_000C,
                32'h0000_0020, 1'b1);
        stall_mode = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule